// File: doc/BRIEF.md
# Maskable Interrupt Entry and Return Sequencer

This controller owns the interrupt-disable bit of a small 8-bit processor core. It decides when an outstanding interrupt request may be serviced. It runs the entry sequence, saving the core's state on the stack and loading the program counter from a vector. It also runs the return sequence that restores that state. Out of reset it fetches the reset vector and leaves the disable bit set.

A request that arrives while interrupts are disabled is held in a pending latch. It is serviced at the first instruction boundary after the core clears the disable bit. On entry, five bytes leave through a push handshake: program counter low, program counter high, index, accumulator and then the condition byte. The disable bit is then set, and the two vector bytes are read, high byte first. A return command pulls the five bytes back in the opposite order. The disable bit is restored from the pulled condition byte. The instruction decoder, the stack pointer and the memory sit outside the block.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset `imask` is 1 and the block reads `vec_addr` 13'h1FFE (high byte) and then 13'h1FFF (low byte). It then pulses `pc_load` once with `pc_out` = {high[4:0], low}.
- R2: While `imask` is 1, a pulse on `irq_req` starts no entry sequence: no push occurs and `busy` stays 0. The request is held pending.
- R3: A `mask_clr` pulse while idle clears `imask`. A pending request is then serviced at the next instruction boundary.
- R4: An entry sequence begins only while idle, with `insn_bound` high, a pending request and `imask` 0. While `insn_bound` is low, no push occurs.
- R5: Entry pushes exactly five bytes in this order: pc[7:0], {3'b000, pc[12:8]}, x, a, and the condition byte {3'b111, H, I, N, Z, C}. The condition byte uses `flags_in` = {H, N, Z, C}, and I is bit 3, holding the value from before entry (0).
- R6: After the fifth push, `imask` is 1. The vector is then read from IRQ_VEC (high byte) and IRQ_VEC+1 (low byte), and `pc_load` pulses with {high[4:0], low}.
- R7: The pending latch clears when entry begins, so a single request pulse produces a single entry.
- R8: An `rti_cmd` pulse while idle pulls five bytes: condition, a, x, pc high, pc low. `regs_load` and `pc_load` then pulse together with the restored a, x, flags and pc. `imask` takes bit 3 of the pulled condition byte.
- R9: A byte moves only on a cycle where `push_valid` and `push_ready` are both high. While the push is stalled, `push_data` holds its value.
- R10: At most one of `push_valid`, `pull_req` and `vec_req` is high in any cycle. `pc_load` pulses only as a sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt request, latched on any cycle it is high |
| mask_clr | input | 1 | Command that clears the disable bit (acted on while idle) |
| rti_cmd | input | 1 | Return-from-interrupt command (acted on while idle) |
| insn_bound | input | 1 | High when the core sits at an instruction boundary |
| pc_in | input | 13 | Current program counter |
| x_in | input | 8 | Current index register |
| a_in | input | 8 | Current accumulator |
| flags_in | input | 4 | Current {H, N, Z, C} |
| push_valid | output | 1 | Push byte offered |
| push_data | output | 8 | Byte to push |
| push_ready | input | 1 | Stack accepts the push |
| pull_req | output | 1 | Pull requested |
| pull_data | input | 8 | Pulled byte |
| pull_ack | input | 1 | Pulled byte valid this cycle |
| vec_req | output | 1 | Vector byte read requested |
| vec_addr | output | 13 | Vector byte address |
| vec_data | input | 8 | Vector byte |
| vec_ack | input | 1 | Vector byte valid this cycle |
| pc_load | output | 1 | One-cycle pulse: load `pc_out` |
| pc_out | output | 13 | New program counter |
| regs_load | output | 1 | One-cycle pulse: load restored a, x and flags |
| a_out | output | 8 | Restored accumulator |
| x_out | output | 8 | Restored index register |
| flags_out | output | 4 | Restored {H, N, Z, C} |
| imask | output | 1 | Interrupt disable bit |
| busy | output | 1 | A sequence is in progress |

## Verification
A pending latch that is lost or fails to clear shows at the push port. The result is either no push burst after the disable bit clears, or a second five-byte burst a few cycles after the first. A wrong byte index or frame ordering shows as a mismatched byte on the very push or pull where it occurs. A wrong vector address or a misrestored frame shows on the `pc_load` pulse that ends the sequence. A wrong disable-bit update shows on `imask` in the cycle after the fifth push or after the first pull.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int unsigned DW          = 8;
  localparam int unsigned PC_W        = 13;
  localparam int unsigned FRAME_BYTES = 5;
  localparam int unsigned IDX_W       = $clog2(FRAME_BYTES);
  localparam int unsigned PCH_W       = PC_W - DW;
  localparam int unsigned IBIT        = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_VEC, ST_PULL} seq_state_e;

  // condition byte: three fixed ones, H, I, N, Z, C
  function automatic logic [DW-1:0] pack_ccr(input logic [3:0] f, input logic i);
    return {3'b111, f[3], i, f[2:0]};
  endfunction

  function automatic logic [3:0] unpack_flags(input logic [DW-1:0] b);
    return {b[4], b[2:0]};
  endfunction

  // frame slot k in push order
  function automatic logic [DW-1:0] frame_byte(input int k, input logic [PC_W-1:0] pc,
                                               input logic [DW-1:0] x, input logic [DW-1:0] a,
                                               input logic [DW-1:0] ccr);
    case (k)
      0:       return pc[DW-1:0];
      1:       return {{(DW-PCH_W){1'b0}}, pc[PC_W-1:DW]};
      2:       return x;
      3:       return a;
      default: return ccr;
    endcase
  endfunction
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic take,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (!rst_n)       pend <= 1'b0;
    else if (take)    pend <= 1'b0;
    else if (irq_req) pend <= 1'b1;
  end

  AST_TAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend); // R4
  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !pend); // R7
endmodule

// File: rtl/irq_mask_reg.sv
import irq_seq_pkg::*;
module irq_mask_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic restore_i,
  input  logic restore_val,
  input  logic clr_i,
  output logic imask
);
  always_ff @(posedge clk) begin
    if (!rst_n)         imask <= 1'b1;
    else if (set_i)     imask <= 1'b1;
    else if (restore_i) imask <= restore_val;
    else if (clr_i)     imask <= 1'b0;
  end

  AST_MASK_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> imask); // R6
  AST_MASK_FROM_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> imask == $past(restore_val)); // R8
endmodule

// File: rtl/irq_seq_core.sv
import irq_seq_pkg::*;
module irq_seq_core #(
  parameter logic [PC_W-1:0] RST_VEC = 13'h1FFE,
  parameter logic [PC_W-1:0] IRQ_VEC = 13'h1FFA
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            entry_start,
  input  logic            rti_start,
  input  logic [PC_W-1:0] pc_in,
  input  logic [DW-1:0]   x_in,
  input  logic [DW-1:0]   a_in,
  input  logic [DW-1:0]   ccr_in,
  output logic            push_valid,
  output logic [DW-1:0]   push_data,
  input  logic            push_ready,
  output logic            pull_req,
  input  logic [DW-1:0]   pull_data,
  input  logic            pull_ack,
  output logic            vec_req,
  output logic [PC_W-1:0] vec_addr,
  input  logic [DW-1:0]   vec_data,
  input  logic            vec_ack,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_out,
  output logic            regs_load,
  output logic [DW-1:0]   a_out,
  output logic [DW-1:0]   x_out,
  output logic [3:0]      flags_out,
  output logic            mask_set,
  output logic            mask_restore,
  output logic            mask_restore_val,
  output logic            idle
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BYTES - 1);

  seq_state_e       state;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    frame [FRAME_BYTES];
  logic [PC_W-1:0]  vec_base;
  logic [DW-1:0]    vec_hi;

  wire push_fire = push_valid && push_ready;
  wire pull_fire = pull_req && pull_ack;
  wire vec_fire  = vec_req && vec_ack;
  wire at_last   = (idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_VEC;
      idx       <= '0;
      vec_base  <= RST_VEC;
      vec_hi    <= '0;
      pc_load   <= 1'b0;
      regs_load <= 1'b0;
      pc_out    <= '0;
      for (int k = 0; k < FRAME_BYTES; k++) frame[k] <= '0;
    end else begin
      pc_load   <= 1'b0;
      regs_load <= 1'b0;
      case (state)
        ST_IDLE: begin
          idx <= '0;
          if (rti_start) state <= ST_PULL;
          else if (entry_start) begin
            state <= ST_PUSH;
            for (int k = 0; k < FRAME_BYTES; k++)
              frame[k] <= frame_byte(k, pc_in, x_in, a_in, ccr_in);
          end
        end
        ST_PUSH: if (push_fire) begin
          if (at_last) begin
            state    <= ST_VEC;
            idx      <= '0;
            vec_base <= IRQ_VEC;
          end else idx <= idx + 1'b1;
        end
        ST_VEC: if (vec_fire) begin
          if (idx == '0) begin
            vec_hi <= vec_data;
            idx    <= idx + 1'b1;
          end else begin
            pc_out  <= {vec_hi[PCH_W-1:0], vec_data};
            pc_load <= 1'b1;
            state   <= ST_IDLE;
            idx     <= '0;
          end
        end
        ST_PULL: if (pull_fire) begin
          frame[LAST - idx] <= pull_data;
          if (at_last) begin
            pc_out    <= {frame[1][PCH_W-1:0], pull_data};
            pc_load   <= 1'b1;
            regs_load <= 1'b1;
            state     <= ST_IDLE;
            idx       <= '0;
          end else idx <= idx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idle             = (state == ST_IDLE);
  assign push_valid       = (state == ST_PUSH);
  assign push_data        = frame[idx];
  assign pull_req         = (state == ST_PULL);
  assign vec_req          = (state == ST_VEC);
  assign vec_addr         = vec_base + PC_W'(idx);
  assign mask_set         = push_fire && at_last;
  assign mask_restore     = pull_fire && (idx == '0);
  assign mask_restore_val = pull_data[IBIT];
  assign a_out            = frame[3];
  assign x_out            = frame[2];
  assign flags_out        = unpack_flags(frame[4]);

  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_data))); // R9
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_valid, pull_req, vec_req})); // R10
  AST_LOAD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> idle); // R10
  AST_REGS_WITH_PC: assert property (@(posedge clk) disable iff (!rst_n)
    regs_load |-> pc_load); // R8
endmodule

// File: rtl/irq_entry_seq.sv
import irq_seq_pkg::*;
module irq_entry_seq #(
  parameter logic [PC_W-1:0] RST_VEC = 13'h1FFE,
  parameter logic [PC_W-1:0] IRQ_VEC = 13'h1FFA
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_req,
  input  logic            mask_clr,
  input  logic            rti_cmd,
  input  logic            insn_bound,
  input  logic [PC_W-1:0] pc_in,
  input  logic [DW-1:0]   x_in,
  input  logic [DW-1:0]   a_in,
  input  logic [3:0]      flags_in,
  output logic            push_valid,
  output logic [DW-1:0]   push_data,
  input  logic            push_ready,
  output logic            pull_req,
  input  logic [DW-1:0]   pull_data,
  input  logic            pull_ack,
  output logic            vec_req,
  output logic [PC_W-1:0] vec_addr,
  input  logic [DW-1:0]   vec_data,
  input  logic            vec_ack,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_out,
  output logic            regs_load,
  output logic [DW-1:0]   a_out,
  output logic [DW-1:0]   x_out,
  output logic [3:0]      flags_out,
  output logic            imask,
  output logic            busy
);
  logic pend, idle, mask_set, mask_restore, mask_restore_val;

  wire rti_start   = idle && rti_cmd;
  wire entry_start = idle && insn_bound && pend && !imask && !rti_cmd;
  wire clr_ok      = idle && mask_clr;

  irq_pend_latch u_pend (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .take(entry_start), .pend(pend)
  );

  irq_mask_reg u_mask (
    .clk(clk), .rst_n(rst_n), .set_i(mask_set), .restore_i(mask_restore),
    .restore_val(mask_restore_val), .clr_i(clr_ok), .imask(imask)
  );

  irq_seq_core #(.RST_VEC(RST_VEC), .IRQ_VEC(IRQ_VEC)) u_core (
    .clk(clk), .rst_n(rst_n), .entry_start(entry_start), .rti_start(rti_start),
    .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .ccr_in(pack_ccr(flags_in, imask)),
    .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
    .pull_req(pull_req), .pull_data(pull_data), .pull_ack(pull_ack),
    .vec_req(vec_req), .vec_addr(vec_addr), .vec_data(vec_data), .vec_ack(vec_ack),
    .pc_load(pc_load), .pc_out(pc_out), .regs_load(regs_load),
    .a_out(a_out), .x_out(x_out), .flags_out(flags_out),
    .mask_set(mask_set), .mask_restore(mask_restore),
    .mask_restore_val(mask_restore_val), .idle(idle)
  );

  assign busy = !idle;

  AST_VEC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> imask); // R6
  AST_NO_PUSH_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && imask && !rti_cmd) |=> !push_valid); // R2
endmodule

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, irq_req = 1'b0, mask_clr = 1'b0, rti_cmd = 1'b0, insn_bound = 1'b0;
  logic [12:0] pc_in = '0;
  logic [7:0] x_in = '0, a_in = '0;
  logic [3:0] flags_in = '0;
  logic push_valid, push_ready = 1'b1, pull_req, pull_ack = 1'b0, vec_req, vec_ack = 1'b0;
  logic [7:0] push_data, pull_data = '0, vec_data = '0;
  logic [12:0] vec_addr, pc_out;
  logic pc_load, regs_load, imask, busy;
  logic [7:0] a_out, x_out;
  logic [3:0] flags_out;

  irq_entry_seq uut (.*);

  int checks = 0, errors = 0, pushes = 0;
  bit stall_push = 0;
  logic [7:0]  exp_push[$];
  logic [12:0] exp_pc[$];
  logic [19:0] exp_regs[$];
  logic [7:0]  stk[$];

  function automatic logic [7:0] vmem(input logic [12:0] ad);
    return {ad[3:0], ~ad[3:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // scoreboard driver: expected frame of one entry
  task automatic expect_entry(input logic [12:0] pc, input logic [7:0] x, input logic [7:0] a,
                              input logic [3:0] f, input logic [12:0] vbase);
    exp_push.push_back(pc[7:0]);
    exp_push.push_back(8'(pc >> 8));
    exp_push.push_back(x);
    exp_push.push_back(a);
    exp_push.push_back(8'hE0 | (8'(f[3]) << 4) | 8'(f[2:0]));
    exp_pc.push_back({vmem(vbase)[4:0], vmem(vbase + 13'd1)});
  endtask

  task automatic pulse_rti; @(negedge clk) rti_cmd = 1; @(negedge clk) rti_cmd = 0; endtask
  task automatic pulse_irq; @(negedge clk) irq_req = 1; @(negedge clk) irq_req = 0; endtask

  task automatic wait_idle;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 300 && busy; i++) @(negedge clk);
  endtask

  // responders and monitor
  initial forever begin
    @(negedge clk);
    push_ready = stall_push ? ~push_ready : 1'b1;
    if (rst_n && push_valid && push_ready) begin
      pushes++;
      stk.push_back(push_data);
      if (exp_push.size() == 0) check("R5 unexpected push", {24'd0, push_data}, 32'hFFFF_FFFF);
      else check("R5 push byte", {24'd0, push_data}, {24'd0, exp_push.pop_front()});
    end
    pull_ack = rst_n && pull_req && stk.size() > 0;
    pull_data = (stk.size() > 0) ? stk[$] : 8'h00;
    if (pull_ack) void'(stk.pop_back());
    vec_ack = vec_req;
    vec_data = vmem(vec_addr);
    if (rst_n && pc_load) begin
      if (exp_pc.size() == 0) check("R10 unexpected pc_load", {19'd0, pc_out}, 32'hFFFF_FFFF);
      else check("R1/R6/R8 pc_out", {19'd0, pc_out}, {19'd0, exp_pc.pop_front()});
    end
    if (rst_n && regs_load) begin
      if (exp_regs.size() == 0) check("R8 unexpected regs_load", 32'd1, 32'd0);
      else check("R8 restored regs", {12'd0, a_out, x_out, flags_out}, {12'd0, exp_regs.pop_front()});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int base;
    exp_pc.push_back({vmem(13'h1FFE)[4:0], vmem(13'h1FFF)});
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 imask after reset", {31'd0, imask}, 32'd1);
    wait_idle();
    check("R1 reset vector loaded", exp_pc.size(), 0);

    // R2: request while masked is held
    pc_in = 13'h1234; x_in = 8'h11; a_in = 8'h22; flags_in = 4'b1010; insn_bound = 1;
    pulse_irq();
    repeat (20) @(negedge clk);
    check("R2 no push while masked", pushes, 0);
    check("R2 busy low while masked", {31'd0, busy}, 32'd0);

    // R3: clearing the mask releases the held request
    expect_entry(13'h1234, 8'h11, 8'h22, 4'b1010, 13'h1FFA);
    @(negedge clk) mask_clr = 1; @(negedge clk) mask_clr = 0;
    wait_idle();
    check("R3 entry after mask clear", pushes, 5);
    check("R6 imask set after entry", {31'd0, imask}, 32'd1);
    check("R6 vector loaded", exp_pc.size(), 0);
    repeat (20) @(negedge clk);
    check("R7 one entry per request", pushes, 5);

    // R8: return restores frame and clears mask
    exp_pc.push_back(13'h1234); exp_regs.push_back({8'h22, 8'h11, 4'b1010});
    pulse_rti();
    wait_idle();
    check("R8 imask restored to 0", {31'd0, imask}, 32'd0);
    check("R8 stack emptied", stk.size(), 0);

    // R4: no entry away from an instruction boundary
    insn_bound = 0;
    pc_in = 13'h0ABC; x_in = 8'h5A; a_in = 8'hC3; flags_in = 4'b0101;
    pulse_irq();
    repeat (15) @(negedge clk);
    check("R4 no entry without boundary", pushes, 5);
    // R9: entry with stalled pushes
    stall_push = 1;
    expect_entry(13'h0ABC, 8'h5A, 8'hC3, 4'b0101, 13'h1FFA);
    @(negedge clk) insn_bound = 1;
    wait_idle();
    stall_push = 0;
    check("R9 stalled entry count", pushes, 10);
    check("R5 all bytes consumed", exp_push.size(), 0);
    exp_pc.push_back(13'h0ABC); exp_regs.push_back({8'hC3, 8'h5A, 4'b0101});
    pulse_rti();
    wait_idle();
    check("R8 second return mask", {31'd0, imask}, 32'd0);

    // R8: frame with I=1 restores a set mask
    base = 0;
    stk.push_back(8'h77); stk.push_back(8'h1F); stk.push_back(8'h33); stk.push_back(8'h44);
    stk.push_back(8'hE8 | 8'h13);
    exp_pc.push_back(13'h1F77); exp_regs.push_back({8'h44, 8'h33, 4'b1011});
    pulse_rti();
    wait_idle();
    check("R8 imask restored to 1", {31'd0, imask}, 32'd1);
    pulse_irq();
    repeat (15) @(negedge clk);
    check("R2 masked after return", pushes, 10 + base);
    check("R10 no leftover loads", exp_pc.size() + exp_regs.size(), 0);
    finish_run();
  end
endmodule